// File: doc/BRIEF.md
# LIN Break Generator and Detector

This block sits beside a UART-style serial port and handles the long dominant symbol that opens a LIN frame. The receive side counts consecutive dominant samples on the line, one per bit-rate tick. It raises a sticky break flag only once the run reaches a selectable threshold of 11 or 12 bit times. A 0x00 data byte seen through a mismatched clock can stretch to about 10.35 bit times, so it is never mistaken for a break. The flag is only a filter: higher-level logic still confirms the true break length.

The transmit side holds back a break request until the data UART has finished its current frame. It then drives the line dominant for a programmed number of whole bit periods and follows that with a recessive delimiter. Outside break generation, the serial stream from the data UART passes through unchanged. The control byte keeps its LIN transmit bit at position 7 and its LIN receive bit at position 6. The data-length mode input picks the shorter or the longer lengths. With both LIN bits clear, the block acts as a plain serial port: a long dominant run is reported as a framing error, and a requested break lasts 10 bits whatever the mode.

Top module: `lin_break_unit`

## Requirements
- R1: After reset, brk_flag and frm_err are 0, tx_brk_busy is 0 and tx_line equals tx_ser_in.
- R2: Only rate_cfg[7] (LIN transmit) and rate_cfg[6] (LIN receive) affect break handling. Bits 5:0 of rate_cfg have no effect.
- R3: With rate_cfg[6]=1, brk_flag rises on the clock after the tick that samples the 11th consecutive dominant (0) rx_line value when long_mode=0, or the 12th when long_mode=1. A run of 10 or fewer never sets it.
- R4: A recessive (1) sample on a tick restarts the dominant run count from zero.
- R5: brk_flag stays 1 until a cycle with brk_clr=1 and no new detection. A detection in the same cycle as brk_clr leaves it set.
- R6: With rate_cfg[6]=0, brk_flag never rises. frm_err pulses for exactly one cycle after the tick that samples the 10th consecutive dominant value, whatever long_mode is.
- R7: With rate_cfg[6]=1, frm_err stays 0.
- R8: With rate_cfg[7]=1, a brk_req makes tx_line dominant from the next accepted tick for exactly 13 bit periods (long_mode=0) or 14 (long_mode=1).
- R9: With rate_cfg[7]=0, a requested break lasts exactly 10 bit periods regardless of long_mode.
- R10: After the dominant period, tx_line is recessive for one bit period while tx_brk_busy stays 1. Then tx_brk_busy falls and tx_line follows tx_ser_in again.
- R11: A request made while tx_busy=1 waits: tx_line keeps following tx_ser_in until a tick with tx_busy=0 starts the break.
- R12: brk_req while a break is pending or in progress is ignored; no second break follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| rate_cfg | input | 8 | Baud/control byte; bit 7 LIN transmit, bit 6 LIN receive |
| long_mode | input | 1 | Data-length mode: 0 short lengths, 1 long lengths |
| rx_line | input | 1 | Serial receive line, 0 is dominant |
| tx_ser_in | input | 1 | Serial stream from the data UART transmitter |
| tx_busy | input | 1 | Data UART is sending a frame |
| brk_req | input | 1 | Request a transmit break |
| brk_clr | input | 1 | Write-one-to-clear strobe for brk_flag |
| tx_line | output | 1 | Serial transmit line |
| tx_brk_busy | output | 1 | Break pending, dominant or in delimiter |
| brk_flag | output | 1 | Sticky break-detected flag |
| frm_err | output | 1 | One-cycle framing-error pulse (plain mode) |

## Verification
The hardest case to reach is the boundary between a stretched 0x00 byte and a real break. A run must stop one sample short of the threshold, and then a run must end exactly on it, in both length modes. The stimulus drives the receive line one value per tick and breaks long runs with a single recessive sample to restart the count. This places runs of 10, 11 and 12 dominant samples at known ticks. The deferred transmit break comes next: the bench holds tx_busy high across several ticks while toggling the UART stream. It then counts dominant periods tick by tick once tx_busy drops.

// File: rtl/lin_brk_pkg.sv
package lin_brk_pkg;

   typedef enum logic [1:0] {
      TXS_IDLE = 2'd0,
      TXS_ARM  = 2'd1,
      TXS_BRK  = 2'd2,
      TXS_DLM  = 2'd3
   } tx_state_e;

   typedef struct packed {
      logic tx_lin;
      logic rx_lin;
   } lin_mode_t;

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/lin_mode_dec.sv
module lin_mode_dec
   import lin_brk_pkg::*;
#(
   parameter int unsigned CFG_W   = 8,
   parameter int unsigned TXEN_POS = 7,
   parameter int unsigned RXEN_POS = 6
) (
   input  logic [CFG_W-1:0] cfg,
   output lin_mode_t        mode
);

   generate
      if (TXEN_POS >= CFG_W || RXEN_POS >= CFG_W || TXEN_POS == RXEN_POS) begin : g_bad_pos
         initial $fatal(1, "lin_mode_dec: control bit positions invalid");
      end
   endgenerate

   always_comb begin
      mode.tx_lin = cfg[TXEN_POS];
      mode.rx_lin = cfg[RXEN_POS];
   end

endmodule

// File: rtl/lin_rx_brk.sv
module lin_rx_brk #(
   parameter int unsigned FE_BITS  = 10,
   parameter int unsigned RX_SHORT = 11,
   parameter int unsigned RX_LONG  = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_tick,
   input  logic rx_line,
   input  logic rx_lin,
   input  logic long_mode,
   input  logic brk_clr,
   output logic brk_flag,
   output logic frm_err
);

   localparam int unsigned CW = $clog2(RX_LONG + 1) + 1;
   localparam logic [CW-1:0] RUN_MAX = {CW{1'b1}};
   localparam logic [CW-1:0] FE_C    = CW'(FE_BITS);
   localparam logic [CW-1:0] SH_C    = CW'(RX_SHORT);
   localparam logic [CW-1:0] LG_C    = CW'(RX_LONG);

   logic [CW-1:0] run_q, run_nx, thr;
   logic          hit_brk, hit_fe, brk_q, fe_q;

   always_comb begin
      if (rx_line)             run_nx = '0;
      else if (run_q == RUN_MAX) run_nx = run_q;
      else                     run_nx = run_q + 1'b1;
      thr     = long_mode ? LG_C : SH_C;
      hit_brk = bit_tick && rx_lin && (run_nx == thr) && (run_q != thr);
      hit_fe  = bit_tick && !rx_lin && (run_nx == FE_C) && (run_q != FE_C);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= '0;
         brk_q <= 1'b0;
         fe_q  <= 1'b0;
      end else begin
         if (bit_tick) run_q <= run_nx;
         if (hit_brk)      brk_q <= 1'b1;
         else if (brk_clr) brk_q <= 1'b0;
         fe_q <= hit_fe;
      end
   end

   assign brk_flag = brk_q;
   assign frm_err  = fe_q;

endmodule

// File: rtl/lin_tx_brk.sv
module lin_tx_brk
   import lin_brk_pkg::*;
#(
   parameter int unsigned TX_PLAIN   = 10,
   parameter int unsigned TX_SHORT   = 13,
   parameter int unsigned TX_LONG    = 14,
   parameter int unsigned DELIM_BITS = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_tick,
   input  logic tx_lin,
   input  logic long_mode,
   input  logic tx_ser_in,
   input  logic tx_busy,
   input  logic brk_req,
   output logic tx_line,
   output logic tx_brk_busy
);

   localparam int unsigned TW = $clog2(max2(max2(TX_LONG, TX_PLAIN), DELIM_BITS) + 1);
   localparam logic [TW-1:0] PL_C = TW'(TX_PLAIN);
   localparam logic [TW-1:0] SH_C = TW'(TX_SHORT);
   localparam logic [TW-1:0] LG_C = TW'(TX_LONG);
   localparam logic [TW-1:0] DL_C = TW'(DELIM_BITS);

   tx_state_e     st_q;
   logic [TW-1:0] cnt_q, len_q, len_sel;

   always_comb begin
      if (!tx_lin)        len_sel = PL_C;
      else if (long_mode) len_sel = LG_C;
      else                len_sel = SH_C;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= TXS_IDLE;
         cnt_q <= '0;
         len_q <= '0;
      end else begin
         unique case (st_q)
            TXS_IDLE: if (brk_req) st_q <= TXS_ARM;
            TXS_ARM: begin
               if (bit_tick && !tx_busy) begin
                  st_q  <= TXS_BRK;
                  cnt_q <= '0;
                  len_q <= len_sel;
               end
            end
            TXS_BRK: begin
               if (bit_tick) begin
                  if (cnt_q == len_q - 1'b1) begin
                     st_q  <= TXS_DLM;
                     cnt_q <= '0;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            TXS_DLM: begin
               if (bit_tick) begin
                  if (cnt_q == DL_C - 1'b1) begin
                     st_q  <= TXS_IDLE;
                     cnt_q <= '0;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            default: st_q <= TXS_IDLE;
         endcase
      end
   end

   always_comb begin
      unique case (st_q)
         TXS_BRK: tx_line = 1'b0;
         TXS_DLM: tx_line = 1'b1;
         default: tx_line = tx_ser_in;
      endcase
      tx_brk_busy = (st_q != TXS_IDLE);
   end

endmodule

// File: rtl/lin_break_unit.sv
module lin_break_unit
   import lin_brk_pkg::*;
#(
   parameter int unsigned CFG_W      = 8,
   parameter int unsigned TXEN_POS   = 7,
   parameter int unsigned RXEN_POS   = 6,
   parameter int unsigned FE_BITS    = 10,
   parameter int unsigned RX_SHORT   = 11,
   parameter int unsigned RX_LONG    = 12,
   parameter int unsigned TX_PLAIN   = 10,
   parameter int unsigned TX_SHORT   = 13,
   parameter int unsigned TX_LONG    = 14,
   parameter int unsigned DELIM_BITS = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_tick,
   input  logic [CFG_W-1:0] rate_cfg,
   input  logic             long_mode,
   input  logic             rx_line,
   input  logic             tx_ser_in,
   input  logic             tx_busy,
   input  logic             brk_req,
   input  logic             brk_clr,
   output logic             tx_line,
   output logic             tx_brk_busy,
   output logic             brk_flag,
   output logic             frm_err
);

   generate
      if (RX_SHORT <= FE_BITS || RX_LONG < RX_SHORT) begin : g_bad_rx
         initial $fatal(1, "lin_break_unit: receive thresholds must exceed the framing limit");
      end
      if (TX_SHORT == 0 || TX_LONG < TX_SHORT || TX_PLAIN == 0 || DELIM_BITS == 0) begin : g_bad_tx
         initial $fatal(1, "lin_break_unit: transmit lengths invalid");
      end
   endgenerate

   lin_mode_t mode;

   lin_mode_dec #(
      .CFG_W   (CFG_W),
      .TXEN_POS(TXEN_POS),
      .RXEN_POS(RXEN_POS)
   ) u_dec (
      .cfg (rate_cfg),
      .mode(mode)
   );

   lin_rx_brk #(
      .FE_BITS (FE_BITS),
      .RX_SHORT(RX_SHORT),
      .RX_LONG (RX_LONG)
   ) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .bit_tick (bit_tick),
      .rx_line  (rx_line),
      .rx_lin   (mode.rx_lin),
      .long_mode(long_mode),
      .brk_clr  (brk_clr),
      .brk_flag (brk_flag),
      .frm_err  (frm_err)
   );

   lin_tx_brk #(
      .TX_PLAIN  (TX_PLAIN),
      .TX_SHORT  (TX_SHORT),
      .TX_LONG   (TX_LONG),
      .DELIM_BITS(DELIM_BITS)
   ) u_tx (
      .clk        (clk),
      .rst_n      (rst_n),
      .bit_tick   (bit_tick),
      .tx_lin     (mode.tx_lin),
      .long_mode  (long_mode),
      .tx_ser_in  (tx_ser_in),
      .tx_busy    (tx_busy),
      .brk_req    (brk_req),
      .tx_line    (tx_line),
      .tx_brk_busy(tx_brk_busy)
   );

endmodule

// File: rtl/lin_break_unit_chk.sv
module lin_break_unit_chk #(
   parameter int unsigned CFG_W    = 8,
   parameter int unsigned RXEN_POS = 6,
   parameter int unsigned RX_SHORT = 11
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bit_tick,
   input logic [CFG_W-1:0] rate_cfg,
   input logic             rx_line,
   input logic             tx_ser_in,
   input logic             brk_clr,
   input logic             tx_line,
   input logic             tx_brk_busy,
   input logic             brk_flag,
   input logic             frm_err
);

   logic [5:0] dom_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dom_cnt <= '0;
      else if (bit_tick) begin
         if (rx_line)               dom_cnt <= '0;
         else if (dom_cnt != 6'h3F) dom_cnt <= dom_cnt + 1'b1;
      end
   end

   // R3: the flag never rises before the short threshold of dominant samples
   a_r3_min_run: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(brk_flag) |-> (dom_cnt >= 6'(RX_SHORT)));

   // R5: the flag is held until cleared
   a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (brk_flag && !brk_clr) |=> brk_flag);

   // R3: detection only happens on a tick
   a_r3_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(brk_flag) |-> $past(bit_tick));

   // R6: framing error is a single-cycle pulse
   a_r6_fe_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      frm_err |=> !frm_err);

   // R7: no framing error while the LIN receive filter is on
   a_r7_no_fe_lin: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rate_cfg[RXEN_POS]) && rate_cfg[RXEN_POS]) |-> !frm_err);

   // R10: outside break handling the UART stream passes through
   a_r10_passthru: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_brk_busy |-> (tx_line == tx_ser_in));

endmodule

bind lin_break_unit lin_break_unit_chk #(
   .CFG_W   (CFG_W),
   .RXEN_POS(RXEN_POS),
   .RX_SHORT(RX_SHORT)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bit_tick   (bit_tick),
   .rate_cfg   (rate_cfg),
   .rx_line    (rx_line),
   .tx_ser_in  (tx_ser_in),
   .brk_clr    (brk_clr),
   .tx_line    (tx_line),
   .tx_brk_busy(tx_brk_busy),
   .brk_flag   (brk_flag),
   .frm_err    (frm_err)
);

// File: tb/tb_lin_break_unit.sv
module tb_lin_break_unit;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_tick = 1'b0;
   logic [7:0] rate_cfg = 8'h00;
   logic       long_mode = 1'b0;
   logic       rx_line = 1'b1;
   logic       tx_ser_in = 1'b1;
   logic       tx_busy = 1'b0;
   logic       brk_req = 1'b0;
   logic       brk_clr = 1'b0;
   logic       tx_line, tx_brk_busy, brk_flag, frm_err;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   lin_break_unit dut (
      .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .rate_cfg(rate_cfg),
      .long_mode(long_mode), .rx_line(rx_line), .tx_ser_in(tx_ser_in),
      .tx_busy(tx_busy), .brk_req(brk_req), .brk_clr(brk_clr),
      .tx_line(tx_line), .tx_brk_busy(tx_brk_busy),
      .brk_flag(brk_flag), .frm_err(frm_err)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // one bit period: tick with rx value; returns frm_err seen after the tick edge
   task automatic tick(input logic rxv, output logic fe);
      @(negedge clk);
      rx_line  = rxv;
      bit_tick = 1'b1;
      @(negedge clk);
      bit_tick = 1'b0;
      fe = frm_err;
      repeat (2) @(negedge clk);
   endtask

   // runs n dominant ticks, returns tick index (1-based) where flag first seen, 0 if never; counts fe pulses
   task automatic dom_run(input int n, output int flag_at, output int fe_cnt);
      logic fe;
      flag_at = 0;
      fe_cnt  = 0;
      for (int i = 1; i <= n; i++) begin
         tick(1'b0, fe);
         if (fe) fe_cnt++;
         if (brk_flag && flag_at == 0) flag_at = i;
      end
   endtask

   task automatic clear_flag();
      @(negedge clk);
      brk_clr = 1'b1;
      @(negedge clk);
      brk_clr = 1'b0;
   endtask

   task automatic idle_line();
      logic fe;
      tick(1'b1, fe);
   endtask

   // counts dominant periods of a break; also reports delimiter check
   task automatic tx_measure(output int dom, output bit dlm_ok, output bit end_ok);
      logic fe;
      dom = 0;
      dlm_ok = 1'b0;
      end_ok = 1'b0;
      for (int i = 0; i < 30; i++) begin
         tick(1'b1, fe);
         if (tx_line == 1'b0) dom++;
         else if (dom > 0) begin
            dlm_ok = tx_brk_busy;
            break;
         end
      end
      tick(1'b1, fe);
      end_ok = !tx_brk_busy && (tx_line == tx_ser_in);
   endtask

   task automatic req_pulse();
      @(negedge clk);
      brk_req = 1'b1;
      @(negedge clk);
      brk_req = 1'b0;
   endtask

   task automatic t_reset();
      chk(brk_flag == 0, "R1 brk_flag", brk_flag, 0);
      chk(frm_err == 0, "R1 frm_err", frm_err, 0);
      chk(tx_brk_busy == 0, "R1 tx_brk_busy", tx_brk_busy, 0);
      chk(tx_line == tx_ser_in, "R1 tx_line", tx_line, tx_ser_in);
   endtask

   task automatic t_rx_thresholds();
      int fa, fc;
      rate_cfg = 8'h40;
      long_mode = 1'b0;
      idle_line();
      dom_run(10, fa, fc);
      chk(fa == 0, "R3 short run 10 no flag", fa, 0);
      chk(fc == 0, "R7 no fe in LIN rx", fc, 0);
      idle_line();
      dom_run(11, fa, fc);
      chk(fa == 11, "R3 flag at 11th", fa, 11);
      idle_line();
      clear_flag();
      chk(brk_flag == 0, "R5 cleared", brk_flag, 1'b0);
      long_mode = 1'b1;
      dom_run(11, fa, fc);
      chk(fa == 0, "R3 long mode no flag at 11", fa, 0);
      dom_run(1, fa, fc);
      chk(fa == 1, "R3 long mode flag at 12", fa, 1);
      dom_run(5, fa, fc);
      chk(brk_flag == 1, "R5 sticky", brk_flag, 1);
      idle_line();
      clear_flag();
   endtask

   task automatic t_rx_restart();
      int fa, fc;
      logic fe;
      rate_cfg = 8'h40;
      long_mode = 1'b0;
      dom_run(8, fa, fc);
      tick(1'b1, fe);
      dom_run(8, fa, fc);
      chk(fa == 0 && brk_flag == 0, "R4 recessive restarts run", brk_flag, 0);
      dom_run(3, fa, fc);
      chk(fa == 3, "R4 flag after fresh 11", fa, 3);
      idle_line();
      clear_flag();
   endtask

   task automatic t_set_vs_clear();
      int fa, fc;
      rate_cfg = 8'h40;
      long_mode = 1'b0;
      dom_run(10, fa, fc);
      @(negedge clk);
      rx_line = 1'b0;
      bit_tick = 1'b1;
      brk_clr = 1'b1;
      @(negedge clk);
      bit_tick = 1'b0;
      brk_clr = 1'b0;
      chk(brk_flag == 1, "R5 set wins over clear", brk_flag, 1);
      idle_line();
      clear_flag();
      chk(brk_flag == 0, "R5 clear strobe", brk_flag, 0);
   endtask

   task automatic t_plain_rx(input logic [7:0] cfg, input logic lm, input string tag);
      int fa, fc;
      rate_cfg = cfg;
      long_mode = lm;
      idle_line();
      dom_run(9, fa, fc);
      chk(fc == 0, {tag, " no fe before 10"}, fc, 0);
      dom_run(1, fa, fc);
      chk(fc == 1, {tag, " fe on 10th"}, fc, 1);
      @(negedge clk);
      chk(frm_err == 0, {tag, " fe one cycle"}, frm_err, 0);
      dom_run(6, fa, fc);
      chk(fc == 0 && brk_flag == 0, {tag, " no break flag"}, brk_flag, 0);
      idle_line();
   endtask

   task automatic t_tx(input logic [7:0] cfg, input logic lm, input int exp, input string tag);
      int d;
      bit dl, en;
      rate_cfg = cfg;
      long_mode = lm;
      tx_ser_in = 1'b1;
      req_pulse();
      chk(tx_brk_busy == 1, {tag, " pending"}, tx_brk_busy, 1);
      tx_measure(d, dl, en);
      chk(d == exp, {tag, " dominant length"}, d, exp);
      chk(dl, "R10 delimiter recessive and busy", dl, 1);
      chk(en, "R10 return to pass-through", en, 1);
   endtask

   task automatic t_tx_wait();
      logic fe;
      int d;
      bit dl, en;
      rate_cfg = 8'h80;
      long_mode = 1'b0;
      tx_busy = 1'b1;
      tx_ser_in = 1'b0;
      req_pulse();
      tick(1'b1, fe);
      chk(tx_line == 0 && tx_brk_busy == 1, "R11 waits, passes 0", tx_line, 0);
      tx_ser_in = 1'b1;
      tick(1'b1, fe);
      chk(tx_line == 1, "R11 waits, passes 1", tx_line, 1);
      tx_busy = 1'b0;
      tx_measure(d, dl, en);
      chk(d == 13, "R11 deferred break length", d, 13);
   endtask

   task automatic t_tx_ignore();
      logic fe;
      int zeros;
      rate_cfg = 8'h80;
      long_mode = 1'b0;
      tx_ser_in = 1'b1;
      req_pulse();
      tick(1'b1, fe);
      tick(1'b1, fe);
      req_pulse();
      zeros = 2;
      for (int i = 0; i < 25; i++) begin
         tick(1'b1, fe);
         if (tx_line == 0) zeros++;
      end
      chk(zeros == 13, "R12 second request ignored", zeros, 13);
      chk(tx_brk_busy == 0, "R12 idle after one break", tx_brk_busy, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_rx_thresholds();
      t_rx_restart();
      t_set_vs_clear();
      t_plain_rx(8'h00, 1'b0, "R6 plain short");
      t_plain_rx(8'h00, 1'b1, "R6 plain long");
      t_plain_rx(8'h3F, 1'b1, "R2 low bits ignored");
      t_tx(8'h80, 1'b0, 13, "R8 tx short");
      t_tx(8'hC0, 1'b1, 14, "R8 tx long both");
      t_tx(8'h00, 1'b0, 10, "R9 plain tx");
      t_tx(8'h3F, 1'b1, 10, "R9 R2 plain tx low bits");
      t_tx_wait();
      t_tx_ignore();
      done = 1'b1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (100000) @(posedge clk);
            total++;
            bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         end
      join_any
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule